// File: doc/BRIEF.md
# I2C Register-Bank Target

This block lets an external I2C controller read and write a bank of 8-bit registers that sit next to it on chip. It watches the two bus wires with a fast local clock, passes them through a short synchroniser, and finds clock edges and the START and STOP conditions in that clock domain. The bus data line is never driven high. The block only asserts an output enable that pulls the line low, and the pad leaves it released otherwise.

A transaction begins with an address byte. If the upper seven bits match the configured device address, the block acknowledges. With the direction bit clear, the next byte loads an 8-bit register pointer. Each byte after that is written to the bank at the pointer, and the pointer then steps forward by one. To read, the controller first writes the pointer and then issues a repeated START with the direction bit set. The block then shifts out register contents from the pointer onward until the controller declines a byte. The all-zero general-call address is accepted only while a configuration input enables it.

The register bank is outside the block. It is reached through a plain port with an address, write data, a one-cycle write strobe and combinational read data.

Top module: `i2c_regbank_target`

## Requirements
- R1: While reset is held, and directly after it, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0x00.
- R2: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. After either, the block releases the data line. After a STOP it stays released until the next START.
- R3: The first byte after a START is taken MSB first. Bits 7..1 are the device address and bit 0 is the direction, where 0 means write and 1 means read. A match with `DEV_ADDR` (default 0x3A) is acknowledged by pulling the data line low in the ninth clock. A mismatch is never acknowledged, and neither is any later byte before the next START.
- R4: In a write, the second byte is acknowledged and loads the register pointer. The third byte is acknowledged and raises `reg_we` for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: After every byte written to the bank, the pointer increments by one, so consecutive data bytes go to consecutive registers until STOP.
- R6: A repeated START keeps the pointer. A matched address with the read bit is acknowledged, and the block then drives `reg_rdata` at the pointer, MSB first, one bit per clock.
- R7: During a read, an acknowledge from the controller makes the block send the register at pointer+1. A not-acknowledge makes it leave the data line released until the next START or STOP.
- R8: The address byte 0x00 (general call, write) is acknowledged and handled as a write only while `gc_en` is 1. While `gc_en` is 0 it is not acknowledged. Address 0x00 with the read bit is never acknowledged.
- R9: A START or STOP in the middle of a byte abandons that byte with no write. The transaction that follows is handled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| gc_en | input | 1 | Enables acceptance of the general-call address |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
A bit counter off by one or a state that misses a clock edge shows up at the ports within one byte time. The acknowledge pulse lands in the wrong clock slot, or read data comes out shifted by a bit, and the controller model sees either one on the very next byte. A pointer that is loaded or incremented at the wrong moment does not disturb the bus. It surfaces only as a write strobe carrying the wrong address, which the bench compares on every clock, or as the wrong byte in a later read. A state machine that fails to resynchronise on START or STOP shows on the transaction that follows the abort.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_HOLD
   } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int CHAIN_W = 2 * SYNC_STAGES;

   logic [CHAIN_W-1:0] chain;
   logic [1:0]         cur;
   logic [1:0]         prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 2'b11;
      end else begin
         chain <= {chain[CHAIN_W-3:0], scl_i, sda_i};
         prev  <= cur;
      end
   end

   assign cur       = chain[CHAIN_W-1 -: 2];
   assign sda_s     = cur[0];
   assign scl_rise  = cur[1] & ~prev[1];
   assign scl_fall  = ~cur[1] & prev[1];
   assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
   assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];

   // R2
   cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !start_det);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              gc_en,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we
);
   localparam int CNT_W = $clog2(BYTE_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  bitcnt;
   logic              done;
   logic              mack;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic [BYTE_W-1:0] ptr;
   logic              addr_hit;

   assign addr_hit = (rx_sr[7:1] == DEV_ADDR) ||
                     (gc_en && rx_sr[7:1] == 7'd0 && !rx_sr[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         done      <= 1'b0;
         mack      <= 1'b0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
         reg_wdata <= '0;
         reg_we    <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         if (start_det) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            done   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_REG, ST_WR: begin
                  if (scl_rise && !done) begin
                     rx_sr  <= {rx_sr[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == CNT_W'(BYTE_W - 1)) done <= 1'b1;
                  end else if (scl_fall && done) begin
                     done   <= 1'b0;
                     bitcnt <= '0;
                     if (state == ST_DEV) begin
                        if (addr_hit) begin
                           sda_oe <= 1'b1;
                           state  <= ST_DEV_ACK;
                        end else begin
                           state  <= ST_HOLD;
                        end
                     end else if (state == ST_REG) begin
                        ptr    <= rx_sr;
                        sda_oe <= 1'b1;
                        state  <= ST_REG_ACK;
                     end else begin
                        reg_wdata <= rx_sr;
                        reg_we    <= 1'b1;
                        sda_oe    <= 1'b1;
                        state     <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: if (scl_fall) begin
                  if (rx_sr[0]) begin
                     tx_sr  <= reg_rdata;
                     sda_oe <= ~reg_rdata[BYTE_W-1];
                     bitcnt <= '0;
                     state  <= ST_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_REG;
                  end
               end
               ST_REG_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WR;
               end
               ST_WR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  ptr    <= ptr + 1'b1;
                  state  <= ST_WR;
               end
               ST_RD: if (scl_fall) begin
                  if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     state  <= ST_RD_ACK;
                  end else begin
                     tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~tx_sr[BYTE_W-2];
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     if (mack) begin
                        tx_sr  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        bitcnt <= '0;
                        state  <= ST_RD;
                     end else begin
                        state  <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_addr = ptr;

   // R4
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && state == ST_DEV));

   // R2
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (!sda_oe && state == ST_IDLE));

   // R5
   ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> $past(scl_fall));

   // R3
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> !sda_oe);

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h3A,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              gc_en,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("byte width must be 8");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .gc_en     (gc_en),
      .reg_rdata (reg_rdata),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we)
   );

endmodule

// File: tb/i2c_regbank_target_test.sv
module i2c_regbank_target_test;
   localparam int         Q   = 10;
   localparam logic [6:0] DEV = 7'h3A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       gc_en = 1'b0;
   logic       sda_oe;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we;
   logic       sda_bus;

   int checks = 0;
   int fails  = 0;
   logic [15:0] expq[$];
   logic [7:0]  bank [256];

   always #10 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_oe;
   assign reg_rdata = bank[reg_addr];

   i2c_regbank_target #(.DEV_ADDR(DEV)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .gc_en(gc_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   initial for (int i = 0; i < 256; i++) bank[i] = 8'h00;
   always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // reference model of the write port, compared every clock (R4 R5 R8 R9)
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R9", "unexpected write addr/data", {reg_addr, reg_wdata}, 0);
         end else begin
            logic [15:0] e;
            e = expq.pop_front();
            chk({reg_addr, reg_wdata} == e, "R4", "write addr/data",
                {reg_addr, reg_wdata}, e);
         end
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic cond_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic cond_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input bit b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic get_byte(output logic [7:0] v, input bit give_ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(!give_ack);
   endtask

   initial begin
      bit         ack, b;
      logic [7:0] v;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
      chk(reg_we == 1'b0, "R1", "reg_we in reset", reg_we, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(reg_addr == 8'h00, "R1", "reg_addr after reset", reg_addr, 0);
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

      // R4 single write
      expq.push_back({8'h10, 8'hA5});
      cond_start();
      send_byte({DEV, 1'b0}, ack); chk(ack, "R3", "ack of matching address", ack, 1);
      send_byte(8'h10, ack);       chk(ack, "R4", "ack of register byte", ack, 1);
      send_byte(8'hA5, ack);       chk(ack, "R4", "ack of data byte", ack, 1);
      cond_stop();
      wq();
      chk(sda_oe == 1'b0, "R2", "released after STOP", sda_oe, 0);

      // R3 mismatched address
      cond_start();
      send_byte({7'h3B, 1'b0}, ack); chk(!ack, "R3", "nack of other address", ack, 0);
      send_byte(8'h10, ack);         chk(!ack, "R3", "nack after mismatch", ack, 0);
      cond_stop();

      // R5 burst write
      expq.push_back({8'h20, 8'h11});
      expq.push_back({8'h21, 8'h22});
      expq.push_back({8'h22, 8'h33});
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h20, ack);
      send_byte(8'h11, ack); chk(ack, "R5", "burst byte 0 ack", ack, 1);
      send_byte(8'h22, ack); chk(ack, "R5", "burst byte 1 ack", ack, 1);
      send_byte(8'h33, ack); chk(ack, "R5", "burst byte 2 ack", ack, 1);
      cond_stop();

      // R6 pointer write, repeated START, single read
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h10, ack);
      cond_start();
      send_byte({DEV, 1'b1}, ack); chk(ack, "R6", "ack of read address", ack, 1);
      get_byte(v, 1'b0);           chk(v == 8'hA5, "R6", "read data", v, 8'hA5);
      wq();
      chk(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
      cond_stop();

      // R7 burst read with controller acks
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h20, ack);
      cond_start();
      send_byte({DEV, 1'b1}, ack);
      get_byte(v, 1'b1); chk(v == 8'h11, "R7", "burst read 0", v, 8'h11);
      get_byte(v, 1'b1); chk(v == 8'h22, "R7", "burst read 1", v, 8'h22);
      get_byte(v, 1'b0); chk(v == 8'h33, "R7", "burst read 2", v, 8'h33);
      get_bit(b);        chk(b == 1'b1, "R7", "line released after nack", b, 1);
      cond_stop();

      // R8 general call
      gc_en = 1'b0;
      cond_start();
      send_byte(8'h00, ack); chk(!ack, "R8", "general call disabled", ack, 0);
      cond_stop();
      gc_en = 1'b1;
      expq.push_back({8'h40, 8'h5C});
      cond_start();
      send_byte(8'h00, ack); chk(ack, "R8", "general call enabled", ack, 1);
      send_byte(8'h40, ack);
      send_byte(8'h5C, ack); chk(ack, "R8", "general call data ack", ack, 1);
      cond_stop();
      cond_start();
      send_byte(8'h01, ack); chk(!ack, "R8", "general call read bit", ack, 0);
      cond_stop();
      gc_en = 1'b0;

      // R9 START in the middle of the register byte
      expq.push_back({8'h50, 8'h77});
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      cond_start();
      send_byte({DEV, 1'b0}, ack); chk(ack, "R9", "ack after abort", ack, 1);
      send_byte(8'h50, ack);
      send_byte(8'h77, ack);       chk(ack, "R9", "data ack after abort", ack, 1);
      cond_stop();
      // R9 STOP in the middle of a data byte
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h60, ack);
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      cond_stop();
      cond_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h60, ack);
      cond_start();
      send_byte({DEV, 1'b1}, ack);
      get_byte(v, 1'b0); chk(v == 8'h00, "R9", "aborted byte not written", v, 0);
      cond_stop();

      chk(expq.size() == 0, "R4", "pending expected writes", expq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule